// File: doc/BRIEF.md
# Ring Buffer Drain Occupancy Tracker

This block does the address and count arithmetic for a ring buffer held in memory. A producer channel fills the ring and a consumer channel drains it. The ring is set by a base address and a size mask, and both sides keep free-running absolute addresses inside it. The block takes the current producer write address and the consumer drain address. From them it derives how many 16-byte quadwords the consumer may still read, the drain address folded back into the ring, and the grant for a consumer request. When a burst would run past the ring top, the grant is split into a first part up to the top and a second part that restarts at the base.

The block also raises a one-cycle empty event. This happens when a completed transfer or tag fetch leaves nothing to read, so that the consumer can park until the producer writes more data. The block moves no data and parses no tags. Base and mask are changed only while the consumer is idle. The mask is a power of two minus 16.

Every output is registered and shows the inputs of the previous clock edge.

Top module: `ring_occ_tracker`

## Requirements
- R1: When the drain address is less than or equal to the producer address, `avail_qw` equals (producer − drain) shifted right by 4, so all counts are in 16-byte quadwords.
- R2: When the drain address is above the producer address, the ring has wrapped, and `avail_qw` equals ((producer − base) + (limit − drain)) shifted right by 4.
- R3: The ring limit is base + mask + 16. `in_ring` is 1 when base ≤ drain ≤ limit, so a drain address equal to the limit still counts as inside.
- R4: `drain_norm` equals base + (drain AND mask). A drain address equal to the limit therefore folds to the base.
- R5: `grant_qw` equals the smaller of `avail_qw` and `req_qw`. `xfer_go` is 1 only when `req_valid` is 1, the drain is inside the ring and the grant is non-zero.
- R6: When the drain is inside the ring and drain + 16·grant is greater than the limit, `split` is 1. In that case `part1_qw` = (limit − drain) >> 4 and `part2_qw` = grant − part1, and the second part starts at the base. Otherwise `split` is 0, `part1_qw` equals the grant and `part2_qw` is 0.
- R7: `empty_pulse` is high for one cycle when `step_done` is sampled while the available count is zero. It fires once per entry into the empty state, and it fires again only after a cycle with a non-zero count has been sampled.
- R8: While `rst` is high, every output is 0.
- R9: Every output changes one clock edge after the inputs it is computed from are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | ADDR_W | Ring base byte address |
| ring_mask | input | ADDR_W | Ring size mask (size − 16) |
| prod_addr | input | ADDR_W | Producer write address |
| drain_addr | input | ADDR_W | Consumer drain address |
| req_valid | input | 1 | Consumer asks for a burst |
| req_qw | input | CNT_W | Quadwords the consumer still needs |
| step_done | input | 1 | A transfer or tag fetch just completed |
| avail_qw | output | AVAIL_W | Quadwords available to drain |
| drain_norm | output | ADDR_W | Drain address folded into the ring |
| in_ring | output | 1 | Drain address lies within base..limit |
| grant_qw | output | CNT_W | Clamped burst length |
| xfer_go | output | 1 | Burst may be issued |
| split | output | 1 | Burst crosses the ring top |
| part1_qw | output | CNT_W | Quadwords before the ring top |
| part2_qw | output | CNT_W | Quadwords from the base |
| empty_pulse | output | 1 | One-cycle empty event |

## Verification
A wrong occupancy branch shows up as a bad `avail_qw` and `grant_qw` on the first cycle after a wrapped address pair is sampled. A wrong fold shows up as a bad `drain_norm` on the first cycle after a drain address at the limit. A corrupted arm state of the empty event is the one fault that stays hidden: it shows only at the next `step_done` sampled with zero occupancy, as a missing or repeated pulse. The bench therefore drives repeated empty steps, then a refill, then a second drain to empty, and it compares every output on every cycle against a behavioural model.

// File: rtl/ring_occ_pkg.sv
package ring_occ_pkg;

  // log2 of the quadword size in bytes
  localparam int unsigned QW_SHIFT = 4;
  localparam int unsigned QW_BYTES = 1 << QW_SHIFT;

  // arm state of the empty event
  typedef enum logic {
    EMPTY_ARMED = 1'b0,
    EMPTY_SPENT = 1'b1
  } empty_arm_t;

endpackage

// File: rtl/ring_occ_calc.sv
module ring_occ_calc
  import ring_occ_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned AVAIL_W = ADDR_W - QW_SHIFT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  base,
  input  logic [ADDR_W-1:0]  mask,
  input  logic [ADDR_W-1:0]  prod,
  input  logic [ADDR_W-1:0]  drain,
  output logic [ADDR_W-1:0]  limit_c,
  output logic [AVAIL_W-1:0] avail_c,
  output logic               in_ring_c,
  output logic [AVAIL_W-1:0] avail_q,
  output logic [ADDR_W-1:0]  norm_q,
  output logic               in_ring_q
);

  logic [ADDR_W-1:0] norm_c;
  logic              vld_q;

  // limit is the first byte past the ring
  always_comb begin
    limit_c = base + mask + ADDR_W'(QW_BYTES);
    if (drain <= prod)
      avail_c = AVAIL_W'((prod - drain) >> QW_SHIFT);
    else
      avail_c = AVAIL_W'(((prod - base) + (limit_c - drain)) >> QW_SHIFT);
    in_ring_c = (drain >= base) && (drain <= limit_c);
    norm_c    = base + (drain & mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      avail_q   <= '0;
      norm_q    <= '0;
      in_ring_q <= 1'b0;
      vld_q     <= 1'b0;
    end else begin
      avail_q   <= avail_c;
      norm_q    <= norm_c;
      in_ring_q <= in_ring_c;
      vld_q     <= 1'b1;
    end
  end

  AST_NORM_INSIDE: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> (norm_q >= $past(base)) && (norm_q <= $past(base) + $past(mask))); // R4

endmodule

// File: rtl/ring_occ_split.sv
module ring_occ_split
  import ring_occ_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned AVAIL_W = ADDR_W - QW_SHIFT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  drain,
  input  logic [ADDR_W-1:0]  limit_c,
  input  logic [AVAIL_W-1:0] avail_c,
  input  logic               in_ring_c,
  input  logic               req_valid,
  input  logic [CNT_W-1:0]   req_qw,
  output logic [CNT_W-1:0]   grant_q,
  output logic               go_q,
  output logic               split_q,
  output logic [CNT_W-1:0]   part1_q,
  output logic [CNT_W-1:0]   part2_q
);

  logic [CNT_W-1:0]  grant_c;
  logic [ADDR_W-1:0] end_addr;
  logic              cross_c;
  logic [CNT_W-1:0]  part1_c;
  logic [CNT_W-1:0]  part2_c;
  logic              go_c;

  always_comb begin
    if (AVAIL_W'(req_qw) <= avail_c) grant_c = req_qw;
    else                             grant_c = CNT_W'(avail_c);
    end_addr = drain + (ADDR_W'(grant_c) << QW_SHIFT);
    cross_c  = in_ring_c && (end_addr > limit_c);
    if (cross_c) begin
      part1_c = CNT_W'((limit_c - drain) >> QW_SHIFT);
      part2_c = grant_c - part1_c;
    end else begin
      part1_c = grant_c;
      part2_c = '0;
    end
    go_c = req_valid && in_ring_c && (grant_c != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      go_q    <= 1'b0;
      split_q <= 1'b0;
      part1_q <= '0;
      part2_q <= '0;
    end else begin
      grant_q <= grant_c;
      go_q    <= go_c;
      split_q <= cross_c;
      part1_q <= part1_c;
      part2_q <= part2_c;
    end
  end

  AST_GRANT_BOUND: assert property (@(posedge clk) disable iff (rst)
    go_q |-> (grant_q != '0) && (grant_q <= $past(req_qw))); // R5
  AST_FIRST_PART_SHORT: assert property (@(posedge clk) disable iff (rst)
    split_q |-> (part1_q < grant_q)); // R6

endmodule

// File: rtl/ring_occ_empty.sv
module ring_occ_empty
  import ring_occ_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic avail_zero_c,
  input  logic step,
  output logic pulse_q
);

  empty_arm_t arm_q;
  logic       fire_c;

  assign fire_c = step && avail_zero_c && (arm_q == EMPTY_ARMED);

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q   <= EMPTY_ARMED;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire_c;
      if (!avail_zero_c) arm_q <= EMPTY_ARMED;
      else if (fire_c)   arm_q <= EMPTY_SPENT;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q); // R7
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> $past(step)); // R7

endmodule

// File: rtl/ring_occ_tracker.sv
module ring_occ_tracker
  import ring_occ_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned AVAIL_W = ADDR_W - QW_SHIFT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  ring_base,
  input  logic [ADDR_W-1:0]  ring_mask,
  input  logic [ADDR_W-1:0]  prod_addr,
  input  logic [ADDR_W-1:0]  drain_addr,
  input  logic               req_valid,
  input  logic [CNT_W-1:0]   req_qw,
  input  logic               step_done,
  output logic [AVAIL_W-1:0] avail_qw,
  output logic [ADDR_W-1:0]  drain_norm,
  output logic               in_ring,
  output logic [CNT_W-1:0]   grant_qw,
  output logic               xfer_go,
  output logic               split,
  output logic [CNT_W-1:0]   part1_qw,
  output logic [CNT_W-1:0]   part2_qw,
  output logic               empty_pulse
);

  logic [ADDR_W-1:0]  limit_c;
  logic [AVAIL_W-1:0] avail_c;
  logic               in_ring_c;

  ring_occ_calc #(.ADDR_W(ADDR_W), .AVAIL_W(AVAIL_W)) u_calc (
    .clk       (clk),
    .rst       (rst),
    .base      (ring_base),
    .mask      (ring_mask),
    .prod      (prod_addr),
    .drain     (drain_addr),
    .limit_c   (limit_c),
    .avail_c   (avail_c),
    .in_ring_c (in_ring_c),
    .avail_q   (avail_qw),
    .norm_q    (drain_norm),
    .in_ring_q (in_ring)
  );

  ring_occ_split #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .AVAIL_W(AVAIL_W)) u_split (
    .clk       (clk),
    .rst       (rst),
    .drain     (drain_addr),
    .limit_c   (limit_c),
    .avail_c   (avail_c),
    .in_ring_c (in_ring_c),
    .req_valid (req_valid),
    .req_qw    (req_qw),
    .grant_q   (grant_qw),
    .go_q      (xfer_go),
    .split_q   (split),
    .part1_q   (part1_qw),
    .part2_q   (part2_qw)
  );

  ring_occ_empty u_empty (
    .clk          (clk),
    .rst          (rst),
    .avail_zero_c (avail_c == '0),
    .step         (step_done),
    .pulse_q      (empty_pulse)
  );

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
    empty_pulse |-> (avail_qw == '0)); // R7
  AST_GO_IN_RING: assert property (@(posedge clk) disable iff (rst)
    xfer_go |-> in_ring); // R5
  AST_SPLIT_IN_RING: assert property (@(posedge clk) disable iff (rst)
    split |-> in_ring); // R6

endmodule

// File: tb/test_ring_occ_tracker.sv
module test_ring_occ_tracker;

  localparam int AW = 32;
  localparam int CW = 16;
  localparam int VW = 28;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] ring_base, ring_mask, prod_addr, drain_addr;
  logic          req_valid, step_done;
  logic [CW-1:0] req_qw;
  logic [VW-1:0] avail_qw;
  logic [AW-1:0] drain_norm;
  logic          in_ring, xfer_go, split, empty_pulse;
  logic [CW-1:0] grant_qw, part1_qw, part2_qw;

  int checks = 0;
  int fails  = 0;
  bit armed  = 1;

  always #5 clk = ~clk;

  ring_occ_tracker i_ring_occ_tracker (
    .clk(clk), .rst(rst), .ring_base(ring_base), .ring_mask(ring_mask),
    .prod_addr(prod_addr), .drain_addr(drain_addr), .req_valid(req_valid),
    .req_qw(req_qw), .step_done(step_done), .avail_qw(avail_qw),
    .drain_norm(drain_norm), .in_ring(in_ring), .grant_qw(grant_qw),
    .xfer_go(xfer_go), .split(split), .part1_qw(part1_qw),
    .part2_qw(part2_qw), .empty_pulse(empty_pulse)
  );

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive one cycle of inputs and compare all outputs one edge later (R9)
  task automatic cycle(bit [31:0] b, bit [31:0] m, bit [31:0] p, bit [31:0] d,
                       bit rv, bit [15:0] rq, bit st);
    bit [31:0] lim, av, nrm, g, p1, p2, endaddr;
    bit inr, go, sp, fire;
    @(negedge clk);
    ring_base = b; ring_mask = m; prod_addr = p; drain_addr = d;
    req_valid = rv; req_qw = rq; step_done = st;
    lim = b + m + 32'd16;
    if (d <= p) av = (p - d) / 16;                  // R1
    else        av = ((p - b) + (lim - d)) / 16;    // R2
    inr = (d >= b) && (d <= lim);                   // R3
    nrm = b + (d & m);                              // R4
    g   = (av < rq) ? av : rq;                      // R5
    go  = rv && inr && (g != 0);
    endaddr = d + g * 16;
    sp  = inr && (endaddr > lim);                   // R6
    p1  = sp ? (lim - d) / 16 : g;
    p2  = sp ? g - p1 : 0;
    fire = st && (av == 0) && armed;                // R7
    if (av != 0) armed = 1;
    else if (fire) armed = 0;
    @(posedge clk);
    #2;
    check("R1/R2", "avail_qw", avail_qw, av);
    check("R3", "in_ring", in_ring, inr);
    check("R4", "drain_norm", drain_norm, nrm);
    check("R5", "grant_qw", grant_qw, g);
    check("R5", "xfer_go", xfer_go, go);
    check("R6", "split", split, sp);
    check("R6", "part1_qw", part1_qw, p1);
    check("R6", "part2_qw", part2_qw, p2);
    check("R7", "empty_pulse", empty_pulse, fire);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog: actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit [31:0] lf;
    rst = 1; ring_base = 32'h1000; ring_mask = 32'h0FF0;
    prod_addr = 32'h1100; drain_addr = 32'h1000;
    req_valid = 1; req_qw = 16'd4; step_done = 1;
    repeat (3) @(posedge clk);
    #2;
    // R8 reset state
    check("R8", "avail_qw", avail_qw, 0);
    check("R8", "grant_qw", grant_qw, 0);
    check("R8", "xfer_go", xfer_go, 0);
    check("R8", "drain_norm", drain_norm, 0);
    check("R8", "empty_pulse", empty_pulse, 0);
    @(negedge clk); rst = 0;

    // R1 plain occupancy
    cycle(32'h1000, 32'h0FF0, 32'h1100, 32'h1000, 1, 8, 0);
    // R2 wrapped occupancy and R6 split 16 + 4
    cycle(32'h1000, 32'h0FF0, 32'h1040, 32'h1F00, 1, 20, 0);
    // R3 drain at the limit counts inside, R4 folds to base, R6 part1 = 0
    cycle(32'h1000, 32'h0FF0, 32'h1080, 32'h2000, 1, 5, 0);
    // R6 burst ending exactly at the limit is not split
    cycle(32'h1000, 32'h0FF0, 32'h1040, 32'h1FC0, 1, 4, 0);
    // R7 empty with a step fires, second step does not
    cycle(32'h1000, 32'h0FF0, 32'h1200, 32'h1200, 1, 4, 1);
    cycle(32'h1000, 32'h0FF0, 32'h1200, 32'h1200, 1, 4, 1);
    // R7 refill re-arms, then drained again fires once more
    cycle(32'h1000, 32'h0FF0, 32'h1210, 32'h1200, 1, 4, 1);
    cycle(32'h1000, 32'h0FF0, 32'h1210, 32'h1210, 1, 4, 1);
    // R5 drain outside the ring never goes
    cycle(32'h1000, 32'h0FF0, 32'h3100, 32'h3000, 1, 4, 0);
    // R5 no request, and zero request
    cycle(32'h1000, 32'h0FF0, 32'h1100, 32'h1000, 0, 4, 0);
    cycle(32'h1000, 32'h0FF0, 32'h1100, 32'h1000, 1, 0, 0);
    // R5 request larger than available is clamped
    cycle(32'h1000, 32'h0FF0, 32'h1030, 32'h1000, 1, 100, 0);

    // mixed patterns inside a second ring
    lf = 32'hACE1_2357;
    for (int i = 0; i < 200; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      cycle(32'h4000, 32'h03F0, 32'h4000 + {22'd0, lf[9:4], 4'd0},
            32'h4000 + {21'd0, lf[20:14], 4'd0}, lf[25], {10'd0, lf[31:26]},
            lf[12]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule